// File: doc/BRIEF.md
# Widen-and-Right-Shift Barrel Shifter

This block is a purely combinational 32-bit shifter. It performs logical left shift, logical right shift, arithmetic right shift and rotate right, all through a single network that only shifts right. First, the 32-bit source word is widened to 63 bits. What goes into the upper 31 bits (or the lower 31 bits for a left shift) is chosen by the operation. The wide word then passes through five 2:1 multiplexer levels. These shift right by 16, 8, 4, 2 and 1 bits, and each level is controlled by one bit of the effective amount. Each level drops the bits that can no longer reach the result, so the word narrows from 63 to 47, 39, 35, 33 and finally 32 bits.

A left shift is mapped onto the same right-shifting network. The source is placed in the upper half of the wide word, with zeros below it, and the amount is replaced by its bitwise complement. A left shift by k therefore becomes a right shift by 31 − k.

The block has no clock and holds no state. The result follows the inputs within the same evaluation. It is meant to sit in the shift leg of an execution unit.

Top module: `shx_barrel`

## Requirements
- R1: With `shift_op` = 2'b00 (logical left), `result_word` equals `src_word` shifted left by `shift_amt`, and the vacated low bits are zero.
- R2: With `shift_op` = 2'b10 (logical right), `result_word` equals `src_word` shifted right by `shift_amt`, and the vacated high bits are zero.
- R3: With `shift_op` = 2'b01 (arithmetic right), `result_word` equals `src_word` shifted right by `shift_amt`, and the vacated high bits are copies of `src_word[31]`.
- R4: With `shift_op` = 2'b11 (rotate right), `result_word` equals `src_word` rotated right by `shift_amt`: bit i of the result is `src_word[(i + shift_amt) mod 32]`.
- R5: With `shift_amt` = 0, `result_word` equals `src_word` for every operation.
- R6: With `shift_amt` = 31, a logical left shift gives `{src_word[0], 31'b0}`, and an arithmetic right shift gives 32 copies of `src_word[31]`.
- R7: The result depends on the current inputs only. A change of the inputs is visible at `result_word` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_word | input | 32 | Word to be shifted or rotated |
| shift_amt | input | 5 | Shift or rotate distance, 0 to 31 |
| shift_op | input | 2 | 00 logical left, 01 arithmetic right, 10 logical right, 11 rotate right |
| result_word | output | 32 | Shifted or rotated word |

## Verification
The hardest cases to reach are the ones that depend on the complemented amount and on the fill bits at the far end of the network. These are left shifts by 0 and by 31, and arithmetic shifts of negative words, where every level must carry the sign copies. The stimulus runs every operation against every amount from 0 to 31. It does this over several source patterns: a negative word with only the sign bit set, an all-ones word, alternating bits, and a one-hot low bit. In this way each multiplexer level is seen both selected and bypassed for each kind of fill.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        OP_LSL = 2'b00,
        OP_ASR = 2'b01,
        OP_LSR = 2'b10,
        OP_ROR = 2'b11
    } shx_op_e;

endpackage

// File: rtl/shx_widen.sv
module shx_widen #(
    parameter int unsigned DW = 32,
    localparam int unsigned EW = 2 * DW - 1
) (
    input  logic [DW-1:0] src_word,
    input  logic [1:0]    shift_op,
    output logic [EW-1:0] wide_word
);
    import shx_pkg::*;

    shx_op_e op_q;
    assign op_q = shx_op_e'(shift_op);

    always_comb begin
        unique case (op_q)
            OP_LSL:  wide_word = {src_word, {(DW-1){1'b0}}};
            OP_ASR:  wide_word = {{(DW-1){src_word[DW-1]}}, src_word};
            OP_LSR:  wide_word = {{(DW-1){1'b0}}, src_word};
            OP_ROR:  wide_word = {src_word[DW-2:0], src_word};
            default: wide_word = '0;
        endcase
    end

endmodule

// File: rtl/shx_amount.sv
module shx_amount #(
    parameter int unsigned AW = 5
) (
    input  logic [AW-1:0] shift_amt,
    input  logic [1:0]    shift_op,
    output logic [AW-1:0] eff_amt
);
    import shx_pkg::*;

    always_comb begin
        if (shx_op_e'(shift_op) == OP_LSL) begin
            eff_amt = ~shift_amt;
        end else begin
            eff_amt = shift_amt;
        end
    end

endmodule

// File: rtl/shx_level.sv
module shx_level #(
    parameter int unsigned DW = 32,
    parameter int unsigned SH = 16,
    localparam int unsigned IN_W  = DW + 2 * SH - 1,
    localparam int unsigned OUT_W = DW + SH - 1
) (
    input  logic [IN_W-1:0]  lvl_in,
    input  logic             sel,
    output logic [OUT_W-1:0] lvl_out
);
    logic [SH-1:0] dropped_low;
    assign dropped_low = lvl_in[SH-1:0];

    always_comb begin
        if (sel) begin
            lvl_out = lvl_in[SH +: OUT_W];
        end else begin
            lvl_out = lvl_in[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/shx_barrel.sv
module shx_barrel #(
    parameter int unsigned DW = 32,
    localparam int unsigned AW = $clog2(DW),
    localparam int unsigned EW = 2 * DW - 1
) (
    input  logic [DW-1:0] src_word,
    input  logic [AW-1:0] shift_amt,
    input  logic [1:0]    shift_op,
    output logic [DW-1:0] result_word
);
    logic [EW-1:0] wide_word;
    logic [AW-1:0] eff_amt;

    shx_widen #(.DW(DW)) widen_i (
        .src_word  (src_word),
        .shift_op  (shift_op),
        .wide_word (wide_word)
    );

    shx_amount #(.AW(AW)) amount_i (
        .shift_amt (shift_amt),
        .shift_op  (shift_op),
        .eff_amt   (eff_amt)
    );

    // Levels run from the largest step (first) to a step of one (last).
    for (genvar g = 0; g < AW; g++) begin : g_lvl
        localparam int unsigned SH    = 1 << (AW - 1 - g);
        localparam int unsigned IN_W  = DW + 2 * SH - 1;
        localparam int unsigned OUT_W = DW + SH - 1;

        logic [IN_W-1:0]  lin;
        logic [OUT_W-1:0] lout;

        if (g == 0) begin : g_head
            assign lin = wide_word;
        end else begin : g_chain
            assign lin = g_lvl[g-1].lout;
        end

        shx_level #(.DW(DW), .SH(SH)) level_i (
            .lvl_in  (lin),
            .sel     (eff_amt[AW-1-g]),
            .lvl_out (lout)
        );
    end

    assign result_word = g_lvl[AW-1].lout;

endmodule

// File: rtl/shx_barrel_chk.sv
module shx_barrel_chk #(
    parameter int unsigned DW = 32,
    localparam int unsigned AW = $clog2(DW)
) (
    input logic [DW-1:0] src_word,
    input logic [AW-1:0] shift_amt,
    input logic [1:0]    shift_op,
    input logic [DW-1:0] result_word
);
    always_comb begin
        // R1: a left shift by a nonzero amount clears bit 0
        if (shift_op == 2'b00 && shift_amt != '0) begin
            a_r1_low_zero: assert (result_word[0] == 1'b0)
                else $error("a_r1_low_zero");
        end
        // R2: a logical right shift by a nonzero amount clears the top bit
        if (shift_op == 2'b10 && shift_amt != '0) begin
            a_r2_top_zero: assert (result_word[DW-1] == 1'b0)
                else $error("a_r2_top_zero");
        end
        // R3: an arithmetic right shift keeps the sign
        if (shift_op == 2'b01) begin
            a_r3_sign_kept: assert (result_word[DW-1] == src_word[DW-1])
                else $error("a_r3_sign_kept");
        end
        // R4: a rotation keeps the number of ones
        if (shift_op == 2'b11) begin
            a_r4_ones_kept: assert ($countones(result_word) == $countones(src_word))
                else $error("a_r4_ones_kept");
        end
        // R5: a zero amount passes the word through
        if (shift_amt == '0) begin
            a_r5_identity: assert (result_word == src_word)
                else $error("a_r5_identity");
        end
        // R6: a left shift by the largest amount keeps only bit 0, moved to the top
        if (shift_op == 2'b00 && shift_amt == '1) begin
            a_r6_lsl_max: assert (result_word == {src_word[0], {(DW-1){1'b0}}})
                else $error("a_r6_lsl_max");
        end
    end
endmodule

bind shx_barrel shx_barrel_chk #(.DW(DW)) chk_i (
    .src_word    (src_word),
    .shift_amt   (shift_amt),
    .shift_op    (shift_op),
    .result_word (result_word)
);

// File: tb/shx_barrel_tb_top.sv
`timescale 1ns/1ps
module shx_barrel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_word = '0;
    logic [4:0]  shift_amt = '0;
    logic [1:0]  shift_op = 2'b00;
    logic [31:0] result_word;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    shx_barrel dut_i (
        .src_word    (src_word),
        .shift_amt   (shift_amt),
        .shift_op    (shift_op),
        .result_word (result_word)
    );

    function automatic logic [31:0] ref_model(input logic [31:0] a,
                                              input logic [4:0] k,
                                              input logic [1:0] op);
        logic [63:0] dbl;
        case (op)
            2'b00:   return a << k;
            2'b01:   return $unsigned($signed(a) >>> k);
            2'b10:   return a >> k;
            default: begin
                dbl = {a, a} >> k;
                return dbl[31:0];
            end
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] op, input logic [4:0] k);
        if (k == 5'd0)  return "R5";
        if (k == 5'd31 && (op == 2'b00 || op == 2'b01)) return "R6";
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R3";
            2'b10:   return "R2";
            default: return "R4";
        endcase
    endfunction

    // Driver: apply one stimulus shortly after a rising edge and queue its expectation.
    task automatic drive(input logic [31:0] a, input logic [4:0] k,
                         input logic [1:0] op, input string req);
        item_t it;
        @(posedge clk);
        #1;
        src_word  = a;
        shift_amt = k;
        shift_op  = op;
        it.exp = ref_model(a, k, op);
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compare at the falling edge, after the inputs have settled.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (result_word !== it.exp) begin
                fails++;
                $display("FAIL %s: op=%b amt=%0d src=%h actual=%h expected=%h",
                         it.req, shift_op, shift_amt, src_word, result_word, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [6];
        pats[0] = 32'h8000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h0000_0001;
        pats[4] = 32'h9234_5678;
        pats[5] = 32'h7F00_00C3;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Idle state: all-zero inputs give a zero result (R5)
        drive(32'h0, 5'd0, 2'b00, "R5");

        // R7: the result tracks the inputs with no extra clock edge
        drive(32'h1234_5678, 5'd4, 2'b10, "R7");
        drive(32'h1234_5678, 5'd4, 2'b00, "R7");

        // R1 R2 R3 R4, with R5 at amount 0 and R6 at amount 31
        for (int p = 0; p < 6; p++) begin
            for (int o = 0; o < 4; o++) begin
                for (int k = 0; k < 32; k++) begin
                    drive(pats[p], 5'(k), 2'(o), req_of(2'(o), 5'(k)));
                end
            end
        end

        // R6 explicit boundary values
        drive(32'h0000_0001, 5'd31, 2'b00, "R6");
        drive(32'h8000_0000, 5'd31, 2'b01, "R6");
        drive(32'h4000_0000, 5'd31, 2'b01, "R6");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule